// File: doc/BRIEF.md
# Masked Calendar Alarm Comparator

This block watches a running calendar and raises an alarm when chosen parts of it reach programmed values. It holds four alarm registers: minute, hour, day of month and day of week. Each has its own enable in its top bit, and that enable is active low. The comparison is made once per minute. A pulse that marks each minute change triggers it, so seconds never take part and the alarm resolves to one minute. A match sets a sticky status flag. Software clears the flag by writing 0 to it. An interrupt output is raised while the flag and an interrupt enable are both set.

The time counters are outside this block. It receives the current minute, hour, date and weekday as BCD values. It also receives a one-cycle minute-change pulse. Software reaches the block through a plain synchronous register port: a write strobe and a read strobe with a shared address. Read data is registered and appears one cycle after the read strobe. The port always accepts an access, so it has no back-pressure and no ready signal. Time inputs and the minute pulse are sampled on every clock edge and are never stalled.

Top module: `cal_alarm_top`

## Requirements
- R1: After reset, the four alarm registers (0x0A minute, 0x0B hour, 0x0C date, 0x0D weekday) read 0x80, registers 0x00 and 0x01 read 0x00, and `irq` is low.
- R2: Read data appears on `rd_data` one cycle after `rd_en`. Register 0x0A keeps all 8 written bits. Registers 0x0B and 0x0C keep bit 7 and bits [5:0]. Register 0x0D keeps bit 7 and bits [2:0]. Register 0x00 keeps only bit 1. Register 0x01 shows only the flag in bit 3. Any unmapped address reads 0x00.
- R3: In each alarm register, bit 7 = 0 includes that field in the match and bit 7 = 1 excludes it. A match requires every included field to equal its current time input. The compared bits are minute [6:0], hour [5:0], date [5:0] and weekday [2:0].
- R4: When all four alarm registers have bit 7 = 1, the flag is never set.
- R5: A match is evaluated only in a cycle where `min_tick` is high. The flag is set at the clock edge that samples that tick, and a matching time without a tick never sets it.
- R6: The flag is sticky. It stays set across later non-matching ticks and is read at bit 3 of register 0x01.
- R7: Writing 0x01 with bit 3 = 0 clears the flag. Writing it with bit 3 = 1 leaves the flag unchanged.
- R8: If a match and a clearing write of 0x01 happen in the same cycle, the flag ends up set.
- R9: `irq` is high exactly while the flag is set and bit 1 of register 0x00 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cur_min | input | 7 | Current minute, BCD |
| cur_hour | input | 6 | Current hour, BCD (24-hour) |
| cur_date | input | 6 | Current day of month, BCD |
| cur_wday | input | 3 | Current day of week |
| min_tick | input | 1 | One-cycle pulse at each minute change |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, valid the cycle after `rd_en` |
| irq | output | 1 | Alarm interrupt, level |

## Verification
The flag and `irq` change at the same clock edge that samples `min_tick` or a write. The bench drives stimulus after a falling edge and checks `irq` at the next falling edge, exactly one edge later. Read data is due one edge after `rd_en`, and the bench samples it at the falling edge that follows that rising edge. The main sweep covers all 16 enable combinations against all 16 match/mismatch patterns of the four fields. Its expected result is computed arithmetically. Separate cases drive a clearing write in the same cycle as a matching tick, and present a matching time with no tick.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
  localparam int REG_W      = 8;
  localparam int N_FIELDS   = 4;
  localparam int EN_BIT     = 7;
  localparam int IE_BIT     = 1;
  localparam int FLAG_BIT   = 3;
  localparam int ADR_IE     = 'h00;
  localparam int ADR_STATUS = 'h01;
  localparam int ADR_ALM0   = 'h0A;

  typedef logic [REG_W-1:0] reg_t;

  // bits kept in an alarm register whose value field is w bits wide
  function automatic reg_t keep_mask(input int w);
    reg_t m;
    m = '0;
    for (int b = 0; b < REG_W; b++) begin
      if (b < w || b == EN_BIT) m[b] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/cal_alarm_field.sv
module cal_alarm_field
  import cal_alarm_pkg::*;
#(
  parameter int W = 6
) (
  input  reg_t         alm_reg,
  input  logic [W-1:0] cur_val,
  output logic         in_use,
  output logic         agrees
);
  assign in_use = ~alm_reg[EN_BIT];
  assign agrees = ~in_use | (alm_reg[W-1:0] == cur_val);
endmodule

// File: rtl/cal_alarm_match.sv
module cal_alarm_match
  import cal_alarm_pkg::*;
#(
  parameter int MIN_W  = 7,
  parameter int HOUR_W = 6,
  parameter int DATE_W = 6,
  parameter int WDAY_W = 3
) (
  input  reg_t [N_FIELDS-1:0] alm,
  input  logic [MIN_W-1:0]    cur_min,
  input  logic [HOUR_W-1:0]   cur_hour,
  input  logic [DATE_W-1:0]   cur_date,
  input  logic [WDAY_W-1:0]   cur_wday,
  input  logic                tick,
  output logic                hit
);
  reg_t [N_FIELDS-1:0] cur_ext;
  logic [N_FIELDS-1:0] used;
  logic [N_FIELDS-1:0] ok;

  assign cur_ext[0] = reg_t'(cur_min);
  assign cur_ext[1] = reg_t'(cur_hour);
  assign cur_ext[2] = reg_t'(cur_date);
  assign cur_ext[3] = reg_t'(cur_wday);

  for (genvar i = 0; i < N_FIELDS; i++) begin : g_fld
    localparam int FW = (i == 0) ? MIN_W : (i == 1) ? HOUR_W :
                        (i == 2) ? DATE_W : WDAY_W;
    cal_alarm_field #(.W(FW)) u_fld (
      .alm_reg (alm[i]),
      .cur_val (cur_ext[i][FW-1:0]),
      .in_use  (used[i]),
      .agrees  (ok[i])
    );
  end

  // R3 and R4: at least one field in use, and every field in use agrees
  assign hit = tick & (|used) & (&ok);
endmodule

// File: rtl/cal_alarm_regs.sv
module cal_alarm_regs
  import cal_alarm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int MIN_W  = 7,
  parameter int HOUR_W = 6,
  parameter int DATE_W = 6,
  parameter int WDAY_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  reg_t                wr_data,
  input  logic                flag,
  output reg_t                rd_data,
  output reg_t [N_FIELDS-1:0] alm,
  output logic                irq_en,
  output logic                clr_req
);
  localparam logic [ADDR_W-1:0] A_IE = ADDR_W'(ADR_IE);
  localparam logic [ADDR_W-1:0] A_ST = ADDR_W'(ADR_STATUS);

  reg_t rd_next;

  for (genvar i = 0; i < N_FIELDS; i++) begin : g_alm
    localparam int FW = (i == 0) ? MIN_W : (i == 1) ? HOUR_W :
                        (i == 2) ? DATE_W : WDAY_W;
    localparam reg_t KEEP = keep_mask(FW);
    localparam logic [ADDR_W-1:0] A_ME = ADDR_W'(ADR_ALM0 + i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        alm[i] <= reg_t'(1) << EN_BIT;
      end else if (wr_en && addr == A_ME) begin
        alm[i] <= wr_data & KEEP;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_en <= 1'b0;
    end else if (wr_en && addr == A_IE) begin
      irq_en <= wr_data[IE_BIT];
    end
  end

  assign clr_req = wr_en && (addr == A_ST) && !wr_data[FLAG_BIT];

  always_comb begin
    rd_next = '0;
    if (addr == A_IE) begin
      rd_next[IE_BIT] = irq_en;
    end else if (addr == A_ST) begin
      rd_next[FLAG_BIT] = flag;
    end
    for (int i = 0; i < N_FIELDS; i++) begin
      if (addr == ADDR_W'(ADR_ALM0 + i)) rd_next = alm[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= rd_next;
    end
  end

  AST_STATUS_READ_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_ST) |=> ((rd_data & ~(reg_t'(1) << FLAG_BIT)) == '0)); // R2
endmodule

// File: rtl/cal_alarm_flag.sv
module cal_alarm_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic clr_req,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
    end else if (hit) begin
      flag <= 1'b1;
    end else if (clr_req) begin
      flag <= 1'b0;
    end
  end

  AST_HIT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag); // R8
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !hit) |=> !flag); // R7
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr_req) |=> flag); // R6
endmodule

// File: rtl/cal_alarm_top.sv
module cal_alarm_top
  import cal_alarm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int MIN_W  = 7,
  parameter int HOUR_W = 6,
  parameter int DATE_W = 6,
  parameter int WDAY_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MIN_W-1:0]  cur_min,
  input  logic [HOUR_W-1:0] cur_hour,
  input  logic [DATE_W-1:0] cur_date,
  input  logic [WDAY_W-1:0] cur_wday,
  input  logic              min_tick,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  output logic              irq
);
  reg_t [N_FIELDS-1:0] alm;
  logic irq_en, clr_req, hit, flag;
  logic all_off;

  cal_alarm_regs #(
    .ADDR_W(ADDR_W), .MIN_W(MIN_W), .HOUR_W(HOUR_W),
    .DATE_W(DATE_W), .WDAY_W(WDAY_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .flag(flag), .rd_data(rd_data), .alm(alm),
    .irq_en(irq_en), .clr_req(clr_req)
  );

  cal_alarm_match #(
    .MIN_W(MIN_W), .HOUR_W(HOUR_W), .DATE_W(DATE_W), .WDAY_W(WDAY_W)
  ) u_match (
    .alm(alm), .cur_min(cur_min), .cur_hour(cur_hour), .cur_date(cur_date),
    .cur_wday(cur_wday), .tick(min_tick), .hit(hit)
  );

  cal_alarm_flag u_flag (
    .clk(clk), .rst_n(rst_n), .hit(hit), .clr_req(clr_req), .flag(flag)
  );

  assign irq = flag & irq_en;

  assign all_off = alm[0][EN_BIT] & alm[1][EN_BIT] & alm[2][EN_BIT] & alm[3][EN_BIT];

  AST_SET_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(min_tick)); // R5
  AST_ALL_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (min_tick && all_off) |=> !$rose(flag)); // R4
  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(ADR_IE) && !wr_data[IE_BIT]) |=> !irq); // R9
endmodule

// File: tb/cal_alarm_top_tb_top.sv
module cal_alarm_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [6:0] cur_min = '0;
  logic [5:0] cur_hour = '0;
  logic [5:0] cur_date = '0;
  logic [2:0] cur_wday = '0;
  logic min_tick = 1'b0;
  logic wr_en = 1'b0;
  logic rd_en = 1'b0;
  logic [7:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic irq;

  int n_checks = 0;
  int n_errs = 0;
  bit done = 1'b0;

  localparam logic [6:0] A_MIN  = 7'h25;
  localparam logic [5:0] A_HOUR = 6'h13;
  localparam logic [5:0] A_DATE = 6'h17;
  localparam logic [2:0] A_WDAY = 3'd3;

  always #10 clk = ~clk;

  cal_alarm_top dut_i (
    .clk(clk), .rst_n(rst_n), .cur_min(cur_min), .cur_hour(cur_hour),
    .cur_date(cur_date), .cur_wday(cur_wday), .min_tick(min_tick),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errs++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    min_tick = 1'b1;
    @(negedge clk);
    min_tick = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_errs++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 irq", int'(irq), 0);
    for (int i = 0; i < 4; i++) begin
      rd(8'h0A + 8'(i), d);
      check("R1 alarm reg", int'(d), 'h80);
    end
    rd(8'h00, d); check("R1 ie reg", int'(d), 0);
    rd(8'h01, d); check("R1 status reg", int'(d), 0);

    // R2 masking on write and read-back
    wr(8'h0A, 8'hFF); rd(8'h0A, d); check("R2 minute keep", int'(d), 'hFF);
    wr(8'h0B, 8'hFF); rd(8'h0B, d); check("R2 hour keep", int'(d), 'hBF);
    wr(8'h0C, 8'hFF); rd(8'h0C, d); check("R2 date keep", int'(d), 'hBF);
    wr(8'h0D, 8'hFF); rd(8'h0D, d); check("R2 wday keep", int'(d), 'h87);
    wr(8'h00, 8'hFF); rd(8'h00, d); check("R2 ie keep", int'(d), 'h02);
    wr(8'h01, 8'hFF); rd(8'h01, d); check("R7 write 1 does not set", int'(d), 0);
    rd(8'h05, d); check("R2 unmapped", int'(d), 0);

    // R3/R4 sweep: ie stays 1 from here
    for (int em = 0; em < 16; em++) begin
      wr(8'h0A, {~em[0], A_MIN});
      wr(8'h0B, {~em[1], 1'b0, A_HOUR});
      wr(8'h0C, {~em[2], 1'b0, A_DATE});
      wr(8'h0D, {~em[3], 4'b0, A_WDAY});
      for (int p = 0; p < 16; p++) begin
        logic exp_hit;
        wr(8'h01, 8'h00);
        @(negedge clk);
        cur_min  = p[0] ? A_MIN  : A_MIN + 7'd1;
        cur_hour = p[1] ? A_HOUR : A_HOUR ^ 6'h01;
        cur_date = p[2] ? A_DATE : A_DATE ^ 6'h20;
        cur_wday = p[3] ? A_WDAY : A_WDAY + 3'd2;
        exp_hit = (em != 0) && ((p & em) == em);
        min_tick = 1'b1;
        @(negedge clk);
        min_tick = 1'b0;
        if (em == 0) check("R4 all fields off", int'(irq), 0);
        else check("R3 field match", int'(irq), int'(exp_hit));
      end
    end

    // enable all fields, current time matches
    wr(8'h0A, {1'b0, A_MIN}); wr(8'h0B, {2'b0, A_HOUR});
    wr(8'h0C, {2'b0, A_DATE}); wr(8'h0D, {5'b0, A_WDAY});
    cur_min = A_MIN; cur_hour = A_HOUR; cur_date = A_DATE; cur_wday = A_WDAY;
    wr(8'h01, 8'h00);
    repeat (5) @(negedge clk);
    check("R5 no tick no flag", int'(irq), 0);
    pulse_tick();
    check("R5 tick sets flag", int'(irq), 1);

    // R6 sticky across a non-matching tick
    cur_min = A_MIN + 7'd1;
    pulse_tick();
    check("R6 sticky", int'(irq), 1);
    rd(8'h01, d); check("R6 flag at bit 3", int'(d), 'h08);

    // R7 write 1 keeps, write 0 clears
    wr(8'h01, 8'h08); check("R7 write 1 keeps", int'(irq), 1);
    wr(8'h01, 8'hF7); check("R7 write 0 clears", int'(irq), 0);

    // R8 simultaneous match and clear
    cur_min = A_MIN;
    @(negedge clk);
    min_tick = 1'b1; wr_en = 1'b1; addr = 8'h01; wr_data = 8'h00;
    @(negedge clk);
    min_tick = 1'b0; wr_en = 1'b0;
    check("R8 match wins over clear", int'(irq), 1);

    // R9 interrupt gating
    wr(8'h00, 8'h00); check("R9 ie off masks irq", int'(irq), 0);
    rd(8'h01, d); check("R9 flag still set", int'(d), 'h08);
    wr(8'h00, 8'h02); check("R9 ie on shows irq", int'(irq), 1);
    wr(8'h01, 8'h00); check("R9 irq drops with flag", int'(irq), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule